// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the fetch address of a 32-bit processor whose instructions are all one word long and word aligned. On every clock edge where the advance enable is high, it loads a new address. That address is picked from three sources, based on the opcode field of the current instruction word and on an equality flag from the datapath:

- the address of the following word;
- a PC-relative branch target;
- a jump target made from the upper PC bits and a word index.

When the advance enable is low, the address is frozen. The unit is placed between instruction fetch and decode. Its two outputs are the current address and the current address plus four. The second output also serves as the link value and the base for branches.

The conditional branch displacement is a signed count of instructions, measured from the address after the branch. The jump target keeps the top four bits of that same address, adds a 26-bit word index, and puts zeros in the two lowest bits.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 0x00400000 (parameter `START_ADDR`). It keeps that value until the first enabled clock edge after release.
- R2: `pc_plus4` always equals `pc_q + 4`, modulo 2^32, in the same cycle.
- R3: On a clock edge where `adv_en` is low, `pc_q` keeps its value, whatever the instruction and flag are.
- R4: On an enabled edge, any opcode (`instr[31:26]`) other than 000100, 000101 or 000010 loads `pc_q + 4`.
- R5: Opcode 000100 with `regs_eq` = 1 loads `pc_q + 4 + (offset << 2)`, where the offset is `instr[15:0]`. With `regs_eq` = 0 it loads `pc_q + 4`.
- R6: Opcode 000101 with `regs_eq` = 0 loads `pc_q + 4 + (offset << 2)`. With `regs_eq` = 1 it loads `pc_q + 4`. For example, 0x16740002 at address X with differing registers goes to X + 12.
- R7: The branch offset is two's complement. When `instr[15]` is 1, the offset is sign-extended, so the branch moves backward.
- R8: Opcode 000010 loads `{pc_plus4[31:28], instr[25:0], 2'b00}`. For example, 0x0810001F leads to 0x0040007C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Advance enable; low holds the address |
| instr | input | 32 | Instruction word fetched at `pc_q` |
| regs_eq | input | 1 | High when the two source registers are equal |
| pc_q | output | 32 | Current fetch address |
| pc_plus4 | output | 32 | Current fetch address plus four |

## Verification
`pc_plus4` is combinational from `pc_q`, so the bench checks it in the same half cycle in which `pc_q` is sampled. Each next address passes through one register. The bench therefore drives the instruction, flag and enable at a falling edge and lets one rising edge pass. It then compares `pc_q` at the next falling edge against a model address that it advances arithmetically. The sweep mixes sequential, taken, not-taken, backward and jump instructions with held cycles. It also covers offset extremes and the worked encodings.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;
  typedef enum logic [1:0] {
    FLOW_SEQ    = 2'd0,
    FLOW_BRANCH = 2'd1,
    FLOW_JUMP   = 2'd2
  } flow_e;

  localparam int unsigned OPC_W    = 6;
  localparam logic [OPC_W-1:0] OPC_BEQ = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BNE = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_JMP = 6'b000010;
endpackage

// File: rtl/pcnu_decode.sv
module pcnu_decode
  import pcnu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  input  logic            regs_eq,
  output flow_e           flow
);
  localparam int unsigned OPC_LSB = XLEN - OPC_W;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc  = instr[XLEN-1:OPC_LSB];
    flow = FLOW_SEQ;
    unique case (opc)
      OPC_BEQ: if (regs_eq)  flow = FLOW_BRANCH;
      OPC_BNE: if (!regs_eq) flow = FLOW_BRANCH;
      OPC_JMP: flow = FLOW_JUMP;
      default: flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/pcnu_target.sv
module pcnu_target #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [XLEN-1:0] pc_plus4,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] jmp_tgt
);
  localparam int unsigned SEXT_W = XLEN - IMM_W - 2;
  localparam int unsigned HI_W   = XLEN - JIDX_W - 2;

  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  disp;

  always_comb begin
    imm     = instr[IMM_W-1:0];
    disp    = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    br_tgt  = pc_plus4 + disp;
    jmp_tgt = {pc_plus4[XLEN-1 -: HI_W], instr[JIDX_W-1:0], 2'b00};
  end
endmodule

// File: rtl/pcnu_reg.sv
module pcnu_reg #(
  parameter int unsigned    XLEN       = 32,
  parameter logic [XLEN-1:0] START_ADDR = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= START_ADDR;
    else if (en) q <= d;
  end

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R3
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcnu_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] START_ADDR = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_en,
  input  logic [31:0]     instr,
  input  logic            regs_eq,
  output logic [31:0]     pc_q,
  output logic [31:0]     pc_plus4
);
  localparam logic [XLEN-1:0] STEP    = XLEN'(4);
  localparam int unsigned     OPC_LSB = XLEN - OPC_W;

  flow_e           flow;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;
  logic [XLEN-1:0] pc_d;

  pcnu_decode #(.XLEN(XLEN)) u_decode (
    .instr   (instr),
    .regs_eq (regs_eq),
    .flow    (flow)
  );

  pcnu_target #(.XLEN(XLEN)) u_target (
    .pc_plus4 (pc_plus4),
    .instr    (instr),
    .br_tgt   (br_tgt),
    .jmp_tgt  (jmp_tgt)
  );

  always_comb begin
    pc_plus4 = pc_q + STEP;
    unique case (flow)
      FLOW_BRANCH: pc_d = br_tgt;
      FLOW_JUMP:   pc_d = jmp_tgt;
      default:     pc_d = pc_plus4;
    endcase
  end

  pcnu_reg #(.XLEN(XLEN), .START_ADDR(START_ADDR)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv_en),
    .d     (pc_d),
    .q     (pc_q)
  );

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00); // R8

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && instr[XLEN-1:OPC_LSB] != OPC_BEQ && instr[XLEN-1:OPC_LSB] != OPC_BNE
     && instr[XLEN-1:OPC_LSB] != OPC_JMP) |=> pc_q == $past(pc_q) + STEP); // R4

  AST_BEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && instr[XLEN-1:OPC_LSB] == OPC_BEQ && !regs_eq)
      |=> pc_q == $past(pc_q) + STEP); // R5

  AST_BNE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && instr[XLEN-1:OPC_LSB] == OPC_BNE && regs_eq)
      |=> pc_q == $past(pc_q) + STEP); // R6

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && instr[XLEN-1:OPC_LSB] == OPC_JMP)
      |=> pc_q[XLEN-1:XLEN-4] == $past(pc_plus4[XLEN-1:XLEN-4])); // R8
endmodule

// File: tb/pc_next_unit_tb.sv
`timescale 1ns/1ps
module pc_next_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        adv_en;
  logic [31:0] instr;
  logic        regs_eq;
  logic [31:0] pc_q;
  logic [31:0] pc_plus4;

  int unsigned n_cmp;
  int unsigned n_bad;
  logic [31:0] model_pc;
  bit          finished;

  pc_next_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (adv_en),
    .instr    (instr),
    .regs_eq  (regs_eq),
    .pc_q     (pc_q),
    .pc_plus4 (pc_plus4)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge load, compare at the next falling edge.
  task automatic step(input string tag, input logic [31:0] iw, input logic eq, input logic en);
    logic [31:0] p4;
    logic [31:0] nxt;
    logic [5:0]  op;
    logic        take;
    p4   = model_pc + 32'd4;
    op   = iw[31:26];
    take = (op == 6'b000100 && eq) || (op == 6'b000101 && !eq);
    if (!en)                nxt = model_pc;
    else if (op == 6'b000010) nxt = {p4[31:28], iw[25:0], 2'b00};
    else if (take)          nxt = p4 + {{14{iw[15]}}, iw[15:0], 2'b00};
    else                    nxt = p4;
    instr   = iw;
    regs_eq = eq;
    adv_en  = en;
    @(negedge clk);
    model_pc = nxt;
    check(tag, pc_q, model_pc);
    check("R2", pc_plus4, model_pc + 32'd4);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; finished = 0;
    rst_n = 1'b0; adv_en = 1'b1; instr = 32'h0; regs_eq = 1'b0;
    model_pc = 32'h0040_0000;
    repeat (3) @(negedge clk);
    check("R1", pc_q, 32'h0040_0000);
    check("R2", pc_plus4, 32'h0040_0004);
    rst_n = 1'b1;
    @(negedge clk);
    adv_en = 1'b0;
    // the first edge after release was enabled with a non-flow opcode
    model_pc = 32'h0040_0004;
    check("R1", pc_q, model_pc);

    step("R4", 32'h0062_2020, 1'b0, 1'b1);
    step("R4", 32'h8C45_0BB8, 1'b1, 1'b1);
    step("R3", 32'h0810_001F, 1'b0, 1'b0);
    step("R3", 32'h1000_0010, 1'b1, 1'b0);
    step("R6", 32'h1674_0002, 1'b0, 1'b1);
    step("R6", 32'h1674_0002, 1'b1, 1'b1);
    step("R5", 32'h1000_0003, 1'b1, 1'b1);
    step("R5", 32'h1000_0003, 1'b0, 1'b1);
    step("R7", 32'h1000_FFFF, 1'b1, 1'b1);
    step("R7", 32'h1400_FFFC, 1'b0, 1'b1);
    step("R7", 32'h1000_8000, 1'b1, 1'b1);
    step("R5", 32'h1000_7FFF, 1'b1, 1'b1);
    step("R8", 32'h0810_001F, 1'b0, 1'b1);
    check("R8", pc_q, 32'h0040_007C);
    step("R6", 32'h1674_0002, 1'b0, 1'b1);
    check("R6", pc_q, 32'h0040_0088);
    step("R8", 32'h0BFF_FFFF, 1'b1, 1'b1);

    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      logic [2:0]  sel;
      logic [31:0] iw;
      string       tg;
      r   = $urandom;
      sel = r[2:0];
      case (sel)
        3'd0: begin iw = {6'b000100, r[31:16], 10'h0} | {16'h0, $urandom_range(0, 65535)}; tg = "R5"; end
        3'd1: begin iw = {6'b000101, 10'h0, 16'h0} | {16'h0, $urandom_range(0, 65535)}; tg = "R6"; end
        3'd2: begin iw = {6'b000010, $urandom_range(0, 32'h3FF_FFFF) & 32'h3FF_FFFF}[31:0]; tg = "R8"; end
        3'd3: begin iw = {6'b000100, 10'h0, 1'b1, 15'(r[30:16])}; tg = "R7"; end
        3'd4: begin iw = $urandom; tg = "R3"; end
        default: begin iw = {6'(r[31:26] | 6'b001000), 26'(r[25:0])}; tg = "R4"; end
      endcase
      if (tg == "R3") step(tg, iw, r[3], 1'b0);
      else            step(tg, iw, r[3], 1'b1);
    end

    rst_n = 1'b0;
    #1;
    model_pc = 32'h0040_0000;
    check("R1", pc_q, model_pc);
    @(negedge clk);
    check("R1", pc_q, model_pc);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule